// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block maps a 15-bit processor address onto an array of twenty-four 1K-word memory devices. The ten low address bits form the word address and go unchanged to every device. The five high bits pick exactly one device by driving its active-low chip select. The selects connect straight to the devices' select pins.

Inside, three identical 3-to-8 slices produce the selects. Each slice has two active-low enables and one active-high enable. The two top address bits drive those enables directly, so slice k wakes only when the top pair equals k. The fourth bank, where the top pair equals 3, is left unpopulated, and no select fires there. An active-high memory-request qualifier goes into each slice's spare enable pin. When it is low, every select stays high.

The block is purely combinational. It holds no state and has no clock.

Top module: `mem_cs_decoder`

## Requirements
- R1: `word_addr_o` always equals `addr_i[9:0]`, whatever the value of `mem_req_i` and of the high address bits.
- R2: With `mem_req_i` high and `addr_i[14:13]` not equal to 3, bit n of `cs_n_o` is low, where n = `addr_i[14:10]`, and all the other bits are high.
- R3: At most one bit of `cs_n_o` is low for any input.
- R4: With `addr_i[14:13]` equal to 3 (addresses 24576 to 32767), all 24 bits of `cs_n_o` are high.
- R5: With `mem_req_i` low, all 24 bits of `cs_n_o` are high for every address.
- R6: Select groups 0–7, 8–15 and 16–23 are driven by slices 0, 1 and 2. Within a group, the low bit position equals `addr_i[12:10]`, with `addr_i[10]` as its LSB.
- R7: The outputs depend only on the present inputs. The same address gives the same result no matter what address came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_req_i | input | 1 | Memory request qualifier, active high |
| addr_i | input | 15 | Processor address |
| word_addr_o | output | 10 | Word address sent to every device |
| cs_n_o | output | 24 | Device chip selects, active low |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and either output. The bench drives a new address and request on each rising clock edge. It compares both outputs on the following falling edge, after the inputs have settled. The sweep covers all 32768 addresses with the request high and again with it low. Randomly ordered vectors then confirm that no result depends on the previous input.

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder #(
  parameter int OFFS_W = 10,
  parameter int SEL_W  = 3
) (
  input  logic                     mem_req_i,
  input  logic [OFFS_W+SEL_W+1:0]  addr_i,
  output logic [OFFS_W-1:0]        word_addr_o,
  output logic [3*(1<<SEL_W)-1:0]  cs_n_o
);
  localparam int LINES    = 1 << SEL_W;
  localparam int SLICES   = 3;
  localparam int BANK_LSB = OFFS_W + SEL_W;

  logic [SEL_W-1:0] code;
  logic             a_lo, a_hi;

  assign word_addr_o = addr_i[OFFS_W-1:0];
  assign code        = addr_i[BANK_LSB-1:OFFS_W];
  assign a_lo        = addr_i[BANK_LSB];
  assign a_hi        = addr_i[BANK_LSB+1];

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic en_a_n, en_b_n, en_c, slice_on;
    if (k == 0) begin : g_w0
      assign en_a_n = a_lo;
      assign en_b_n = a_hi;
      assign en_c   = mem_req_i;
    end else if (k == 1) begin : g_w1
      assign en_a_n = a_hi;
      assign en_b_n = ~mem_req_i;
      assign en_c   = a_lo;
    end else begin : g_w2
      assign en_a_n = a_lo;
      assign en_b_n = ~mem_req_i;
      assign en_c   = a_hi;
    end
    assign slice_on = ~en_a_n & ~en_b_n & en_c;
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign cs_n_o[k*LINES+i] = ~(slice_on && (code == SEL_W'(i)));
    end
  end
endmodule

// File: rtl/mem_cs_decoder_chk.sv
module mem_cs_decoder_chk #(
  parameter int OFFS_W = 10,
  parameter int SEL_W  = 3
) (
  input logic                     mem_req_i,
  input logic [OFFS_W+SEL_W+1:0]  addr_i,
  input logic [OFFS_W-1:0]        word_addr_o,
  input logic [3*(1<<SEL_W)-1:0]  cs_n_o
);
  localparam int CS_W = 3 * (1 << SEL_W);
  localparam int TOP  = OFFS_W + SEL_W + 1;

  logic [1:0]           bank;
  logic [SEL_W+1:0]     idx;
  assign bank = addr_i[TOP:TOP-1];
  assign idx  = addr_i[TOP:OFFS_W];

  always_comb begin
    assert_word_pass_R1: assert (word_addr_o == addr_i[OFFS_W-1:0]);
    assert_exclusive_R3: assert ($onehot0(~cs_n_o));
    if (bank == 2'd3)
      assert_hole_quiet_R4: assert (&cs_n_o);
    if (!mem_req_i)
      assert_idle_quiet_R5: assert (&cs_n_o);
    if (mem_req_i && bank != 2'd3)
      assert_hit_select_R2: assert (cs_n_o == ~(CS_W'(1) << idx));
  end
endmodule

bind mem_cs_decoder mem_cs_decoder_chk #(.OFFS_W(OFFS_W), .SEL_W(SEL_W)) u_chk (
  .mem_req_i(mem_req_i), .addr_i(addr_i), .word_addr_o(word_addr_o), .cs_n_o(cs_n_o)
);

// File: tb/tb_mem_cs_decoder.sv
module tb_mem_cs_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        mem_req_i;
  logic [14:0] addr_i;
  logic [9:0]  word_addr_o;
  logic [23:0] cs_n_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  mem_cs_decoder dut (
    .mem_req_i(mem_req_i), .addr_i(addr_i), .word_addr_o(word_addr_o), .cs_n_o(cs_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] exp_cs(input logic req, input logic [14:0] a);
    logic [23:0] r;
    r = '1;
    if (req && a[14:13] != 2'd3) r[a[14:10]] = 1'b0;
    return r;
  endfunction

  task automatic apply_check(input logic req, input logic [14:0] a, input string tag);
    @(posedge clk);
    mem_req_i = req;
    addr_i    = a;
    @(negedge clk);
    n_cmp++;
    if (cs_n_o !== exp_cs(req, a)) begin
      n_bad++;
      $display("FAIL %s cs_n addr=%0d req=%0b got=%h exp=%h", tag, a, req, cs_n_o, exp_cs(req, a));
    end
    n_cmp++;
    if (word_addr_o !== a[9:0]) begin
      n_bad++;
      $display("FAIL R1 word addr=%0d got=%0d exp=%0d", a, word_addr_o, a[9:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    mem_req_i = 1'b0;
    addr_i    = '0;
    // R5: idle state, no request
    apply_check(1'b0, 15'd0, "R5");
    // R6: first and last line of each slice
    apply_check(1'b1, 15'd0,     "R6");
    apply_check(1'b1, 15'd7168,  "R6");
    apply_check(1'b1, 15'd8192,  "R6");
    apply_check(1'b1, 15'd16383, "R6");
    apply_check(1'b1, 15'd16384, "R6");
    apply_check(1'b1, 15'd24575, "R6");
    // R4: unpopulated bank edges
    apply_check(1'b1, 15'd24576, "R4");
    apply_check(1'b1, 15'd32767, "R4");
    // R5: request low inside populated banks
    apply_check(1'b0, 15'd5120,  "R5");
    apply_check(1'b0, 15'd20000, "R5");
    // R2 / R3 / R4: full sweep with request high
    for (int a = 0; a < 32768; a++) apply_check(1'b1, 15'(a), "R2");
    // R5: full sweep with request low
    for (int a = 0; a < 32768; a++) apply_check(1'b0, 15'(a), "R5");
    // R7: random order, no history dependence
    for (int i = 0; i < 2000; i++)
      apply_check(1'($urandom_range(1, 0)), 15'($urandom_range(32767, 0)), "R7");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule